// File: doc/BRIEF.md
# Branching Program Counter

This unit produces the program-memory address for a small 8-bit microcoded processor. On each clock it does one of four things, chosen by the microcode strobes: clear, load, step or hold. It steps by one past every fetched program byte. On a taken jump it loads a target built from two address registers. It clears on a synchronous clear strobe and holds otherwise. The low target register supplies the low address byte and the high target register supplies the address bits above it. The two registers can be written one at a time from the data byte, or together from a full address operand in one cycle.

The active-low jump strobe suppresses stepping during its cycle, whatever the condition outcome. The counter already points at the next instruction when a branch is evaluated, so a branch that is not taken must leave the address unchanged. A condition-select field picks which flag qualifies the jump.

The per-cycle decision is an enumerated operation with four named values:
- OP_CLEAR is chosen when the clear strobe is high.
- OP_LOAD is chosen when the jump strobe is low and the condition holds.
- OP_STEP is chosen when the jump strobe is high and the increment strobe is high.
- OP_HOLD is chosen in every other case: a not-taken jump, or no strobe.

Each operation sets the address register at the next clock edge.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc_addr` is 0 and both target registers are 0, so a taken jump right after reset goes to address 0.
- R2: `clr` high forces `pc_addr` to 0 at the next edge, overriding any jump and increment in the same cycle.
- R3: With `clr` low, `jmp_n` high and `inc` high, `pc_addr` advances by one at the next edge and wraps from 0xFFF to 0x000.
- R4: With `clr` low, `jmp_n` low and the selected condition true, `pc_addr` becomes {high register, low register} at the next edge; the high register keeps 4 bits.
- R5: With `clr` low, `jmp_n` low and the selected condition false, `pc_addr` does not change, even with `inc` high.
- R6: `cond_sel` encoding: 0 = always, 1 = zero flag `flags[0]`, 2 = carry flag `flags[1]`, 3 = negative flag `flags[2]`.
- R7: `ld_lo` writes `data_in` into the low register and `ld_hi` writes `data_in[3:0]` into the high register at the next edge. A jump in the same cycle uses the values held before that write.
- R8: `ld_pair` writes `imm_addr[7:0]` to the low register and `imm_addr[11:8]` to the high register in one cycle, overriding `ld_lo` and `ld_hi`.
- R9: With `clr` low, `jmp_n` high and `inc` low, `pc_addr` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Microcode clear strobe, synchronous |
| inc | input | 1 | Microcode increment strobe |
| jmp_n | input | 1 | Active-low jump strobe |
| cond_sel | input | 2 | Jump condition select |
| flags | input | 3 | Flags: zero, carry, negative (bit 0 up) |
| ld_lo | input | 1 | Write low target register from `data_in` |
| ld_hi | input | 1 | Write high target register from `data_in` |
| ld_pair | input | 1 | Write both target registers from `imm_addr` |
| data_in | input | 8 | Data byte for single-register writes |
| imm_addr | input | 12 | Full address operand for the paired write |
| pc_addr | output | 12 | Program address |

## Verification
The hardest case to reach is a jump whose condition is false while the increment strobe is also high. This is the only situation that separates a correct counter from one that slips forward by one and skips an opcode. The stimulus walks every condition code with its flag both set and clear, always with increment asserted. It also writes a target register in the same cycle as a jump, so the bench can tell old values from new ones. Because the target registers have no output, their contents are made visible by a later taken jump that copies them onto the address.

// File: rtl/pc_branch_pkg.sv
package pc_branch_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_HOLD  = 2'd3
    } pc_op_e;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'd0,
        COND_ZERO   = 2'd1,
        COND_CARRY  = 2'd2,
        COND_NEG    = 2'd3
    } cond_e;

    localparam int FLAG_ZERO  = 0;
    localparam int FLAG_CARRY = 1;
    localparam int FLAG_NEG   = 2;

endpackage

// File: rtl/pc_cond_eval.sv
module pc_cond_eval
    import pc_branch_pkg::*;
#(
    parameter int COND_W = 2,
    parameter int FLAG_W = 3
) (
    input  logic [COND_W-1:0] cond_sel,
    input  logic [FLAG_W-1:0] flags,
    output logic              cond_ok
);

    cond_e sel;

    always_comb begin
        sel = cond_e'(cond_sel);
        unique case (sel)
            COND_ALWAYS: cond_ok = 1'b1;
            COND_ZERO:   cond_ok = flags[FLAG_ZERO];
            COND_CARRY:  cond_ok = flags[FLAG_CARRY];
            COND_NEG:    cond_ok = flags[FLAG_NEG];
            default:     cond_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pc_op_decode.sv
module pc_op_decode
    import pc_branch_pkg::*;
(
    input  logic   clr,
    input  logic   inc,
    input  logic   jmp_n,
    input  logic   cond_ok,
    output pc_op_e op
);

    // Priority: clear, then jump (taken loads, not-taken holds), then step.
    always_comb begin
        if (clr)
            op = OP_CLEAR;
        else if (!jmp_n)
            op = cond_ok ? OP_LOAD : OP_HOLD;
        else if (inc)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/pc_target_regs.sv
module pc_target_regs #(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8,
    localparam int HI_W  = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              ld_pair,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [ADDR_W-1:0] imm_addr,
    output logic [ADDR_W-1:0] target
);

    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (ld_pair) begin
            lo_q <= imm_addr[BYTE_W-1:0];
            hi_q <= imm_addr[ADDR_W-1:BYTE_W];
        end else begin
            if (ld_lo) lo_q <= data_in;
            if (ld_hi) hi_q <= data_in[HI_W-1:0];
        end
    end

    assign target = {hi_q, lo_q};

    AST_PAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pair |=> target == $past(imm_addr)); // R8

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !ld_pair) |=> lo_q == $past(data_in)); // R7

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
    import pc_branch_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8,
    parameter int COND_W = 2,
    parameter int FLAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              jmp_n,
    input  logic [COND_W-1:0] cond_sel,
    input  logic [FLAG_W-1:0] flags,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              ld_pair,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [ADDR_W-1:0] imm_addr,
    output logic [ADDR_W-1:0] pc_addr
);

    logic              cond_ok;
    pc_op_e            op;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    pc_cond_eval #(.COND_W(COND_W), .FLAG_W(FLAG_W)) u_cond (
        .cond_sel (cond_sel),
        .flags    (flags),
        .cond_ok  (cond_ok)
    );

    pc_op_decode u_dec (
        .clr     (clr),
        .inc     (inc),
        .jmp_n   (jmp_n),
        .cond_ok (cond_ok),
        .op      (op)
    );

    pc_target_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .ld_pair  (ld_pair),
        .data_in  (data_in),
        .imm_addr (imm_addr),
        .target   (target)
    );

    always_comb begin
        unique case (op)
            OP_CLEAR: pc_d = '0;
            OP_LOAD:  pc_d = target;
            OP_STEP:  pc_d = pc_q + 1'b1;
            OP_HOLD:  pc_d = pc_q;
            default:  pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_addr = pc_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pc_addr == '0); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && jmp_n && inc) |=> pc_addr == ADDR_W'($past(pc_addr) + 1'b1)); // R3

    AST_TAKEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !jmp_n && cond_ok) |=> pc_addr == $past(target)); // R4

    AST_NOT_TAKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !jmp_n && !cond_ok) |=> $stable(pc_addr)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && jmp_n && !inc) |=> $stable(pc_addr)); // R9

endmodule

// File: tb/tb_pc_branch_unit.sv
`timescale 1ns/1ps
module tb_pc_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, inc = 1'b0, jmp_n = 1'b1;
    logic [1:0]  cond_sel = 2'd0;
    logic [2:0]  flags = 3'd0;
    logic        ld_lo = 1'b0, ld_hi = 1'b0, ld_pair = 1'b0;
    logic [7:0]  data_in = 8'd0;
    logic [11:0] imm_addr = 12'd0;
    logic [11:0] pc_addr;

    int checks = 0;
    int errors = 0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    logic [11:0] m_pc = 12'd0;
    logic [7:0]  m_lo = 8'd0;
    logic [3:0]  m_hi = 4'd0;

    always #4 clk = ~clk;

    pc_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .jmp_n(jmp_n),
        .cond_sel(cond_sel), .flags(flags), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .ld_pair(ld_pair), .data_in(data_in), .imm_addr(imm_addr),
        .pc_addr(pc_addr)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    // Driver: one clock of stimulus, expected address pushed to the scoreboard.
    task automatic step(input logic i_clr, input logic i_inc, input logic i_jmp_n,
                        input logic [1:0] i_cond, input logic [2:0] i_flags,
                        input logic i_lo, input logic i_hi, input logic i_pair,
                        input logic [7:0] i_data, input logic [11:0] i_imm,
                        input string tag);
        logic cond_true;
        @(negedge clk);
        clr = i_clr; inc = i_inc; jmp_n = i_jmp_n; cond_sel = i_cond;
        flags = i_flags; ld_lo = i_lo; ld_hi = i_hi; ld_pair = i_pair;
        data_in = i_data; imm_addr = i_imm;
        case (i_cond) // R6 encoding
            2'd0: cond_true = 1'b1;
            2'd1: cond_true = i_flags[0];
            2'd2: cond_true = i_flags[1];
            default: cond_true = i_flags[2];
        endcase
        if (i_clr)                      m_pc = 12'd0;
        else if (!i_jmp_n && cond_true) m_pc = {m_hi, m_lo};
        else if (i_jmp_n && i_inc)      m_pc = m_pc + 12'd1;
        if (i_pair) begin
            m_lo = i_imm[7:0];
            m_hi = i_imm[11:8];
        end else begin
            if (i_lo) m_lo = i_data;
            if (i_hi) m_hi = i_data[3:0];
        end
        exp_q.push_back(m_pc);
        tag_q.push_back(tag);
    endtask

    task automatic fetch(input string tag);
        step(0, 1, 1, 2'd0, 3'd0, 0, 0, 0, 8'd0, 12'd0, tag);
    endtask

    task automatic jump(input logic [1:0] c, input logic [2:0] f, input string tag);
        step(0, 1, 0, c, f, 0, 0, 0, 8'd0, 12'd0, tag);
    endtask

    // Monitor: compares away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) check(tag_q.pop_front(), pc_addr, exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset address", pc_addr, 12'd0);
        @(negedge clk);
        rst_n = 1'b1;
        jump(2'd0, 3'd0, "R1 targets cleared by reset");
        for (int i = 0; i < 5; i++) fetch("R3 straight fetch");
        step(0, 0, 1, 2'd0, 3'd0, 0, 0, 0, 8'd0, 12'd0, "R9 idle hold");
        step(0, 0, 1, 2'd0, 3'd7, 0, 0, 0, 8'd0, 12'd0, "R9 idle hold flags");
        step(0, 1, 1, 2'd0, 3'd0, 1, 0, 0, 8'h34, 12'd0, "R7 low write with fetch");
        step(0, 1, 1, 2'd0, 3'd0, 0, 1, 0, 8'hA2, 12'd0, "R7 high write with fetch");
        jump(2'd0, 3'd0, "R4 always jump to 0x234");
        step(0, 1, 0, 2'd0, 3'd0, 1, 0, 0, 8'h99, 12'd0, "R7 jump uses old low value");
        jump(2'd0, 3'd0, "R7 new low value visible");
        step(0, 1, 1, 2'd0, 3'd0, 1, 1, 1, 8'h11, 12'hFFE, "R8 pair write overrides");
        jump(2'd0, 3'd0, "R8 pair target 0xFFE");
        fetch("R3 to 0xFFF");
        fetch("R3 wrap to 0x000");
        fetch("R3 after wrap");
        step(0, 1, 1, 2'd0, 3'd0, 0, 0, 1, 8'd0, 12'h5C3, "R8 pair write");
        for (int c = 1; c < 4; c++) begin
            jump(c[1:0], 3'd0, "R5 not-taken holds with inc");
            jump(c[1:0], ~(3'd1 << (c - 1)), "R6 other flags do not qualify");
            fetch("R3 fetch after not-taken");
            jump(c[1:0], 3'd1 << (c - 1), "R6 selected flag taken");
            fetch("R3 fetch after taken");
        end
        step(0, 0, 0, 2'd3, 3'd0, 0, 0, 0, 8'd0, 12'd0, "R5 not-taken without inc");
        step(1, 1, 0, 2'd0, 3'd0, 0, 0, 0, 8'd0, 12'd0, "R2 clear beats jump");
        fetch("R3 after clear");
        step(1, 1, 1, 2'd0, 3'd0, 0, 0, 0, 8'd0, 12'd0, "R2 clear beats inc");
        jump(2'd0, 3'd0, "R4 jump back to 0x5C3");
        @(negedge clk);
        clr = 0; inc = 0; jmp_n = 1; ld_lo = 0; ld_hi = 0; ld_pair = 0;
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule